// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block converts between the NRZ serial bits of a UART and the short return-to-zero pulses of a slow infrared link. On the transmit side, each zero bit becomes a narrow pulse and each one bit leaves the line at rest. On the receive side, each detected pulse is stretched back into a full-length zero bit for the UART receiver. Each direction has its own enable. When a direction is disabled, plain UART signalling passes through it unchanged.

All logic runs on one system clock. A one-cycle strobe marks each 16x baud tick, and the encoder counts these ticks to find its position inside a bit. Every transition of the UART transmit bit realigns that count, because the UART only changes its output at bit boundaries. Two pulse widths are available: three sixteenths of the bit, placed mid-bit, or a fixed number of system clocks derived from parameters. The encoder and the decoder each have their own polarity control.

Top module: `irSirCodec`

## Requirements
- R1: With txIrEn low, irTxOut equals the txBit value sampled one clock earlier.
- R2: With rxIrEn low, rxBit equals irRxIn delayed by two clocks through a two-stage synchronizer.
- R3: With txIrEn high and txFixedWidth low, a zero bit drives irTxOut active while the in-bit tick count is 7, 8 or 9. The count restarts at 0 on each txBit transition. irTxOut is registered, so it lags by one clock.
- R4: A one bit produces no pulse. In IrDA transmit mode, irTxOut rests at the inactive level, which is the value of txInvert.
- R5: With txFixedWidth high, the tick that moves a zero bit's count from 6 to 7 starts a pulse. That pulse lasts exactly CLK_MHZ*PULSE_NS/1000 system clocks, and a later start reloads it.
- R6: With txInvert low, the active transmit level is 1. With txInvert high, it is 0.
- R7: With rxInvert low, the decoder treats a high level as a pulse. With rxInvert high, it treats a low level as a pulse.
- R8: With rxIrEn high, the start of each synchronized pulse drives rxBit low for HOLD_TICKS (16) baud ticks. A new pulse start reloads the count, and rxBit can only return high on a tick.
- R9: When a txBit transition and a baud tick fall in the same clock, the transition wins: the tick count restarts at 0 and the tick is not counted.
- R10: After reset, irTxOut and rxBit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| txIrEn | input | 1 | Transmit path in IrDA mode when 1 |
| rxIrEn | input | 1 | Receive path in IrDA mode when 1 |
| txFixedWidth | input | 1 | 1 selects the fixed clock-count pulse; 0 selects the 3/16-bit pulse |
| txInvert | input | 1 | 1 makes the transmitted pulse active-low |
| rxInvert | input | 1 | 1 makes the decoder expect active-low pulses |
| txBit | input | 1 | NRZ serial bit from the UART transmitter |
| irRxIn | input | 1 | Raw line from the infrared receiver |
| irTxOut | output | 1 | Line to the infrared emitter |
| rxBit | output | 1 | NRZ serial bit to the UART receiver |

## Verification
Two events can land in the same clock: a txBit transition and a baud tick, or a received pulse start and a baud tick. The transition must restart the bit count, and the pulse start must reload the hold count. The bench provokes both by lining up frames so that every bit edge falls on a tick cycle, and by running the encoder output back into the decoder. A behavioural model compares both outputs against the design on every clock, so it would catch a pulse that shifts by one tick or a hold that ends one tick early.

// File: rtl/irSirPkg.sv
package irSirPkg;
  // Strobes handed from the timing controllers to the datapath
  typedef struct packed {
    logic txPulse;  // encoder pulse window is open
    logic rxHold;   // decoder is stretching a received pulse
  } irStrobeT;
endpackage

// File: rtl/irSirTxTiming.sv
module irSirTxTiming #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3,
  parameter int PULSE_CLKS    = 325
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudTick,
  input  logic txBit,
  input  logic txFixedWidth,
  output logic txPulse
);
  localparam int PHASE_W = $clog2(TICKS_PER_BIT);
  localparam int FIX_W   = $clog2(PULSE_CLKS + 1);
  localparam logic [PHASE_W-1:0] PH_LAST  = PHASE_W'(TICKS_PER_BIT - 1);
  localparam logic [PHASE_W-1:0] PH_ARM   = PHASE_W'(PULSE_START - 1);
  localparam logic [PHASE_W-1:0] PH_FIRST = PHASE_W'(PULSE_START);
  localparam logic [PHASE_W-1:0] PH_END   = PHASE_W'(PULSE_START + PULSE_LEN - 1);
  localparam logic [FIX_W-1:0]   FIX_LOAD = FIX_W'(PULSE_CLKS);

  logic               txPrev;
  logic [PHASE_W-1:0] phase;
  logic [FIX_W-1:0]   fixCnt;
  logic               bitEdge;
  logic               pulseFrac;
  logic               pulseFix;

  assign bitEdge = txBit ^ txPrev;

  // Position inside the current bit; every UART transition marks a boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev <= 1'b1;
      phase  <= '0;
    end else begin
      txPrev <= txBit;
      if (bitEdge)
        phase <= '0;
      else if (baudTick)
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  // Fixed-width pulse: armed by the tick that enters the start position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      fixCnt <= '0;
    else if (!bitEdge && baudTick && phase == PH_ARM && !txPrev)
      fixCnt <= FIX_LOAD;
    else if (fixCnt != '0)
      fixCnt <= fixCnt - 1'b1;
  end

  assign pulseFrac = !txPrev && (phase >= PH_FIRST) && (phase <= PH_END);
  assign pulseFix  = (fixCnt != '0);
  assign txPulse   = txFixedWidth ? pulseFix : pulseFrac;
endmodule

// File: rtl/irSirRxTiming.sv
module irSirRxTiming #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudTick,
  input  logic rxActive,
  output logic rxHold
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_TICKS);

  logic              activePrev;
  logic [HOLD_W-1:0] holdCnt;
  logic              pulseStart;

  assign pulseStart = rxActive && !activePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePrev <= 1'b1;
      holdCnt    <= '0;
    end else begin
      activePrev <= rxActive;
      if (pulseStart)
        holdCnt <= HOLD_LOAD;
      else if (baudTick && holdCnt != '0)
        holdCnt <= holdCnt - 1'b1;
    end
  end

  assign rxHold = (holdCnt != '0);
endmodule

// File: rtl/irSirDatapath.sv
module irSirDatapath
  import irSirPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  irStrobeT strobes,
  input  logic     txIrEn,
  input  logic     rxIrEn,
  input  logic     txInvert,
  input  logic     rxInvert,
  input  logic     txBit,
  input  logic     irRxIn,
  output logic     rxActive,
  output logic     irTxOut,
  output logic     rxBit
);
  logic syncA;
  logic syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= irRxIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irTxOut <= 1'b1;
    else if (txIrEn)
      irTxOut <= strobes.txPulse ^ txInvert;
    else
      irTxOut <= txBit;
  end

  assign rxActive = syncB ^ rxInvert;
  assign rxBit    = rxIrEn ? !strobes.rxHold : syncB;
endmodule

// File: rtl/irSirCodec.sv
module irSirCodec
  import irSirPkg::*;
#(
  parameter int CLK_MHZ       = 200,
  parameter int PULSE_NS      = 1627,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3,
  parameter int HOLD_TICKS    = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudTick16,
  input  logic txIrEn,
  input  logic rxIrEn,
  input  logic txFixedWidth,
  input  logic txInvert,
  input  logic rxInvert,
  input  logic txBit,
  input  logic irRxIn,
  output logic irTxOut,
  output logic rxBit
);
  localparam int PULSE_CLKS = (CLK_MHZ * PULSE_NS) / 1000;

  irStrobeT strobes;
  logic     txPulse;
  logic     rxHold;
  logic     rxActive;

  assign strobes.txPulse = txPulse;
  assign strobes.rxHold  = rxHold;

  irSirTxTiming #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_START  (PULSE_START),
    .PULSE_LEN    (PULSE_LEN),
    .PULSE_CLKS   (PULSE_CLKS)
  ) uTxTiming (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick16),
    .txBit       (txBit),
    .txFixedWidth(txFixedWidth),
    .txPulse     (txPulse)
  );

  irSirRxTiming #(
    .HOLD_TICKS(HOLD_TICKS)
  ) uRxTiming (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick16),
    .rxActive(rxActive),
    .rxHold  (rxHold)
  );

  irSirDatapath uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txIrEn  (txIrEn),
    .rxIrEn  (rxIrEn),
    .txInvert(txInvert),
    .rxInvert(rxInvert),
    .txBit   (txBit),
    .irRxIn  (irRxIn),
    .rxActive(rxActive),
    .irTxOut (irTxOut),
    .rxBit   (rxBit)
  );
endmodule

// File: rtl/irSirCodecChk.sv
module irSirCodecChk (
  input logic clk,
  input logic rstN,
  input logic baudTick16,
  input logic txIrEn,
  input logic rxIrEn,
  input logic txFixedWidth,
  input logic txInvert,
  input logic txBit,
  input logic irRxIn,
  input logic irTxOut,
  input logic rxBit
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sinceRst <= '0;
    else if (sinceRst != 2'd3)
      sinceRst <= sinceRst + 1'b1;
  end

  assert_tx_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txIrEn |=> irTxOut == $past(txBit));

  assert_rx_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rxIrEn && sinceRst == 2'd3) |-> rxBit == $past(irRxIn, 2));

  assert_tx_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txIrEn && !txFixedWidth && $past(txBit)) |=> irTxOut == $past(txInvert));

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrEn && $past(rxIrEn) && !$past(rxBit) && !$past(baudTick16)) |-> !rxBit);
endmodule

bind irSirCodec irSirCodecChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .baudTick16  (baudTick16),
  .txIrEn      (txIrEn),
  .rxIrEn      (rxIrEn),
  .txFixedWidth(txFixedWidth),
  .txInvert    (txInvert),
  .txBit       (txBit),
  .irRxIn      (irRxIn),
  .irTxOut     (irTxOut),
  .rxBit       (rxBit)
);

// File: tb/tb_irSirCodec.sv
`timescale 1ns/100ps
module tb_irSirCodec;
  localparam int FIX_CLKS = 20;   // 200 MHz * 100 ns
  localparam int BIT_CLKS = 64;   // 16 ticks of 4 clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick16 = 1'b0;
  logic txIrEn = 1'b0, rxIrEn = 1'b0, txFixedWidth = 1'b0;
  logic txInvert = 1'b0, rxInvert = 1'b0;
  logic txBit = 1'b1, rxDrv = 1'b1, loopOn = 1'b0;
  logic irRxIn, irTxOut, rxBit;

  int vectors = 0, miscompares = 0, tickDiv = 0;
  bit checking = 1'b0, done = 1'b0;
  string curReq = "R10";

  // behavioural model state
  int mPrev = 1, mPhase = 0, mFix = 0, mOut = 1;
  int mS1 = 1, mS2 = 1, mActPrev = 1, mHold = 0;

  always #2.5 clk = ~clk;

  assign irRxIn = loopOn ? irTxOut : rxDrv;

  irSirCodec #(.PULSE_NS(100)) dut (
    .clk(clk), .rstN(rstN), .baudTick16(baudTick16),
    .txIrEn(txIrEn), .rxIrEn(rxIrEn), .txFixedWidth(txFixedWidth),
    .txInvert(txInvert), .rxInvert(rxInvert),
    .txBit(txBit), .irRxIn(irRxIn), .irTxOut(irTxOut), .rxBit(rxBit)
  );

  always @(negedge clk) begin
    tickDiv <= (tickDiv + 1) % 4;
    baudTick16 <= (tickDiv == 3);
  end

  // Reference model, advanced on each rising edge from stable inputs
  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 1; mPhase = 0; mFix = 0; mOut = 1;
      mS1 = 1; mS2 = 1; mActPrev = 1; mHold = 0;
    end else begin
      int rxIn, act, nOut, pulse, edgeNow, tick;
      rxIn = loopOn ? mOut : int'(rxDrv);
      tick = int'(baudTick16);
      edgeNow = (int'(txBit) != mPrev);
      if (txFixedWidth) pulse = (mFix > 0);
      else pulse = (mPrev == 0 && mPhase >= 7 && mPhase <= 9);
      nOut = txIrEn ? (pulse ^ int'(txInvert)) : int'(txBit);
      if (!edgeNow && tick && mPhase == 6 && mPrev == 0) mFix = FIX_CLKS;
      else if (mFix > 0) mFix = mFix - 1;
      if (edgeNow) mPhase = 0;
      else if (tick) mPhase = (mPhase + 1) % 16;
      mPrev = int'(txBit);
      mOut = nOut;
      act = mS2 ^ int'(rxInvert);
      if (act && !mActPrev) mHold = 16;
      else if (tick && mHold > 0) mHold = mHold - 1;
      mActPrev = act;
      mS2 = mS1;
      mS1 = rxIn;
    end
  end

  always @(negedge clk) begin
    #1;
    if (checking) begin
      int expRx;
      expRx = rxIrEn ? (mHold == 0) : mS2;
      vectors++;
      if (int'(irTxOut) != mOut) begin
        miscompares++;
        $display("FAIL %s irTxOut actual=%0d expected=%0d t=%0t", curReq, irTxOut, mOut, $time);
      end
      vectors++;
      if (int'(rxBit) != expRx) begin
        miscompares++;
        $display("FAIL %s rxBit actual=%0d expected=%0d t=%0t", curReq, rxBit, expRx, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input int align);
    do @(negedge clk); while (tickDiv != align);
    txBit = 1'b0; idle(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      txBit = b[i]; idle(BIT_CLKS);
    end
    txBit = 1'b1; idle(2 * BIT_CLKS);
  endtask

  initial begin
    idle(8);
    // R10: reset state
    vectors++;
    if (irTxOut !== 1'b1 || rxBit !== 1'b1) begin
      miscompares++;
      $display("FAIL R10 reset outputs actual=%b%b expected=11", irTxOut, rxBit);
    end
    rstN = 1'b1;
    checking = 1'b1;

    // R1, R2: both paths transparent
    curReq = "R1";
    fork
      sendFrame(8'hA5, 1);
      begin
        for (int k = 0; k < 40; k++) begin
          rxDrv = ~rxDrv; idle(7 + (k % 5) * 6);
        end
        rxDrv = 1'b1;
      end
    join
    curReq = "R2"; idle(BIT_CLKS);

    // R3, R4, R8: 3/16 pulses fed back into the decoder
    txIrEn = 1'b1; rxIrEn = 1'b1; loopOn = 1'b1; idle(BIT_CLKS);
    curReq = "R3"; sendFrame(8'h55, 2);
    curReq = "R3"; sendFrame(8'h00, 1);
    curReq = "R4"; sendFrame(8'hFF, 3);

    // R9: every transition lands on a tick cycle
    curReq = "R9"; sendFrame(8'h3C, 0);
    curReq = "R9"; sendFrame(8'h81, 0);

    // R6, R7: inverted polarity on both sides
    txInvert = 1'b1; rxInvert = 1'b1; idle(3 * BIT_CLKS);
    curReq = "R6"; sendFrame(8'h69, 1);
    curReq = "R7"; sendFrame(8'h00, 0);

    // R5: fixed-width pulses, both polarities
    txFixedWidth = 1'b1;
    curReq = "R5"; sendFrame(8'h4A, 2);
    txInvert = 1'b0; rxInvert = 1'b0; idle(3 * BIT_CLKS);
    curReq = "R5"; sendFrame(8'h00, 0);
    txFixedWidth = 1'b0;

    // R8: retriggered and isolated pulses from the line
    loopOn = 1'b0; rxDrv = 1'b0; idle(BIT_CLKS);
    curReq = "R8";
    for (int k = 0; k < 6; k++) begin
      rxDrv = 1'b1; idle(3); rxDrv = 1'b0; idle(30);
    end
    idle(2 * BIT_CLKS);
    rxDrv = 1'b1; idle(5); rxDrv = 1'b0; idle(2 * BIT_CLKS);

    // R1 again while decoder keeps running
    curReq = "R1"; txIrEn = 1'b0; sendFrame(8'hC3, 3);
    checking = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule